// File: doc/BRIEF.md
# Reset Sequencer with Boot ROM Overlay

This block produces the processor reset and halt lines for a small system and makes the boot ROM visible at low memory after every reset. Three events can start a reset. Power-good low forces reset at once and holds it for a long, prescaled interval after power returns. A press of the debounced reset button gives a short pulse. A software strobe gives a medium pulse. Reset and halt always move together, so every reset is a full processor reset.

From every reset onward, an overlay flag forces the top bit of the outgoing physical address high. The processor's first fetches from address zero therefore land in the ROM window (0x800000 to 0xBFFFFF), and RAM is inhibited. Boot code ends the overlay by writing one control value to one control address. Writes anywhere else have no effect on the flag.

Top module: `boot_reset_seq`

## Requirements
- R1: While `pwr_good_i` is low, `sys_rst_n_o` and `sys_halt_n_o` are 0 and `ram_inhibit_o` is 1, taking effect without waiting for a clock edge.
- R2: After `pwr_good_i` rises, reset is released on the PRE_DIV*PWR_TICKS-th rising clock edge. The defaults give 1,000,000 cycles, which is 100 ms at 10 MHz.
- R3: A rising edge on `btn_i` (sampled at a clock edge) asserts reset from that edge for BTN_CYCLES (10) cycles. Keeping the button held does not start another reset.
- R4: A one-cycle `sw_rst_i` strobe asserts reset from the sampling edge for SW_CYCLES (124) cycles. If a strobe and a button edge arrive in the same cycle, the strobe is used.
- R5: `sys_halt_n_o` always equals `sys_rst_n_o`.
- R6: A request that arrives while reset is active restarts the count from that edge. The new length is that of the longer class: power-up > software > button.
- R7: Every reset source sets the overlay flag, and the flag stays set after reset ends.
- R8: While the overlay is set, `phys_addr_o` equals `cpu_addr_i` with bit 23 forced to 1. Otherwise `phys_addr_o` equals `cpu_addr_i`.
- R9: `ram_inhibit_o` is 1 exactly while the overlay flag is set.
- R10: A cycle with `cpu_wr_i`=1, `cpu_addr_i`=0xE43000 and `cpu_data_i`=0x8000, while reset is inactive, clears the flag at that edge. Any other address, any other data, `cpu_wr_i`=0, or a write during reset leaves the flag unchanged.
- R11: If a reset request and a clearing write occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| pwr_good_i | input | 1 | Power good; low forces reset asynchronously |
| btn_i | input | 1 | Debounced reset button level, high = pressed |
| sw_rst_i | input | 1 | Software reset strobe, one cycle |
| cpu_addr_i | input | 24 | Processor byte address |
| cpu_wr_i | input | 1 | Processor write strobe, one cycle per write |
| cpu_data_i | input | 16 | Processor write data |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_halt_n_o | output | 1 | Processor halt, active low, same as reset |
| phys_addr_o | output | 24 | Physical address after the overlay |
| ram_inhibit_o | output | 1 | High while RAM accesses are blocked |

## Verification
The hardest cases to reach are the ones where reset requests overlap. A second request has to land on a chosen edge while a first reset is still counting, and one of them is a power-up hold whose prescaled count must restart rather than be cut short. The stimulus places the second request at a fixed edge index relative to the first, for every pairing of source classes. It then counts edges until release and compares the count with the sum worked out from the class lengths. The flag-clearing decode is swept by flipping each address and data bit in turn around the one accepted write.

// File: rtl/boot_rst_pkg.sv
package boot_rst_pkg;

    // Source classes, ordered so that a larger value means a longer hold.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BTN  = 2'd1,
        SRC_SW   = 2'd2,
        SRC_PWR  = 2'd3
    } rst_src_e;

endpackage

// File: rtl/rst_request_gen.sv
module rst_request_gen
    import boot_rst_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_n_i,
    input  logic     btn_i,
    input  logic     sw_rst_i,
    output logic     req_valid_o,
    output rst_src_e req_src_o
);

    typedef struct packed {
        logic btn;
    } req_state_t;

    req_state_t st_d, st_q;
    logic       btn_edge;

    always_comb begin
        st_d       = st_q;
        st_d.btn   = btn_i;
        btn_edge   = btn_i & ~st_q.btn;
        req_valid_o = btn_edge | sw_rst_i;
        if (sw_rst_i) begin
            req_src_o = SRC_SW;
        end else if (btn_edge) begin
            req_src_o = SRC_BTN;
        end else begin
            req_src_o = SRC_NONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    btn_held_no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (btn_i && $past(btn_i) && !sw_rst_i) |-> !req_valid_o);

    // R4
    sw_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sw_rst_i |-> (req_src_o == SRC_SW));

endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer
    import boot_rst_pkg::*;
#(
    parameter int PRE_DIV    = 1000,
    parameter int PWR_TICKS  = 1000,
    parameter int BTN_CYCLES = 10,
    parameter int SW_CYCLES  = 124
) (
    input  logic     clk_i,
    input  logic     rst_n_i,
    input  logic     req_valid_i,
    input  rst_src_e req_src_i,
    output logic     active_o
);

    localparam int MAX_AB  = (BTN_CYCLES > SW_CYCLES) ? BTN_CYCLES : SW_CYCLES;
    localparam int MAX_LEN = (MAX_AB > PWR_TICKS) ? MAX_AB : PWR_TICKS;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int PRE_W   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
    localparam logic [CNT_W-1:0] LEN_PWR  = CNT_W'(PWR_TICKS - 1);
    localparam logic [CNT_W-1:0] LEN_BTN  = CNT_W'(BTN_CYCLES - 1);
    localparam logic [CNT_W-1:0] LEN_SW   = CNT_W'(SW_CYCLES - 1);

    typedef struct packed {
        rst_src_e         src;
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        tick;
    rst_src_e    nxt_src;

    function automatic logic [CNT_W-1:0] len_of(input rst_src_e s);
        case (s)
            SRC_PWR: len_of = LEN_PWR;
            SRC_SW:  len_of = LEN_SW;
            SRC_BTN: len_of = LEN_BTN;
            default: len_of = '0;
        endcase
    endfunction

    always_comb begin
        st_d    = st_q;
        tick    = (st_q.src != SRC_PWR) || (st_q.pre == PRE_LAST);
        nxt_src = SRC_NONE;
        if (st_q.src != SRC_NONE) begin
            if (st_q.src == SRC_PWR) begin
                st_d.pre = (st_q.pre == PRE_LAST) ? '0 : st_q.pre + 1'b1;
            end
            if (tick) begin
                if (st_q.cnt == '0) begin
                    st_d.src = SRC_NONE;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
        if (req_valid_i) begin
            nxt_src  = (st_q.src > req_src_i) ? st_q.src : req_src_i;
            st_d.src = nxt_src;
            st_d.cnt = len_of(nxt_src);
            st_d.pre = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.src <= SRC_PWR;
            st_q.cnt <= LEN_PWR;
            st_q.pre <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.src != SRC_NONE);

    // R6
    no_demote_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (req_valid_i && st_q.src == SRC_PWR) |=> (st_q.src == SRC_PWR && st_q.pre == '0));

    // R2
    early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q.src != SRC_NONE && st_q.cnt != '0) |=> (st_q.src != SRC_NONE));

    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q.src == SRC_BTN) |-> (st_q.cnt <= LEN_BTN));

    // R4
    req_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        req_valid_i |=> active_o);

endmodule

// File: rtl/boot_overlay_flag.sv
module boot_overlay_flag #(
    parameter int                ADDR_W   = 24,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 24'hE43000,
    parameter logic [DATA_W-1:0] CLR_DATA = 16'h8000
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              set_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              flag_o
);

    typedef struct packed {
        logic flag;
    } ovl_state_t;

    ovl_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = wr_i && (addr_i == CLR_ADDR) && (data_i == CLR_DATA);
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (hit) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R10
    clear_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(st_q.flag) |-> $past(wr_i && !set_i));

    // R11
    set_dominates_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        set_i |=> st_q.flag);

endmodule

// File: rtl/addr_overlay_map.sv
module addr_overlay_map #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              overlay_i,
    output logic [ADDR_W-1:0] phys_o,
    output logic              ram_inhibit_o
);

    localparam logic [ADDR_W-1:0] TOP_BIT = {1'b1, {(ADDR_W-1){1'b0}}};

    always_comb begin
        phys_o        = overlay_i ? (addr_i | TOP_BIT) : addr_i;
        ram_inhibit_o = overlay_i;
    end

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
    import boot_rst_pkg::*;
#(
    parameter int PRE_DIV    = 1000,
    parameter int PWR_TICKS  = 1000,
    parameter int BTN_CYCLES = 10,
    parameter int SW_CYCLES  = 124,
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 24'hE43000,
    parameter logic [DATA_W-1:0] CLR_DATA = 16'h8000
) (
    input  logic              clk_i,
    input  logic              pwr_good_i,
    input  logic              btn_i,
    input  logic              sw_rst_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] cpu_data_i,
    output logic              sys_rst_n_o,
    output logic              sys_halt_n_o,
    output logic [ADDR_W-1:0] phys_addr_o,
    output logic              ram_inhibit_o
);

    logic     req_valid;
    rst_src_e req_src;
    logic     hold_active;
    logic     overlay;

    rst_request_gen u_req (
        .clk_i       (clk_i),
        .rst_n_i     (pwr_good_i),
        .btn_i       (btn_i),
        .sw_rst_i    (sw_rst_i),
        .req_valid_o (req_valid),
        .req_src_o   (req_src)
    );

    rst_hold_timer #(
        .PRE_DIV    (PRE_DIV),
        .PWR_TICKS  (PWR_TICKS),
        .BTN_CYCLES (BTN_CYCLES),
        .SW_CYCLES  (SW_CYCLES)
    ) u_timer (
        .clk_i       (clk_i),
        .rst_n_i     (pwr_good_i),
        .req_valid_i (req_valid),
        .req_src_i   (req_src),
        .active_o    (hold_active)
    );

    boot_overlay_flag #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CLR_ADDR (CLR_ADDR),
        .CLR_DATA (CLR_DATA)
    ) u_flag (
        .clk_i   (clk_i),
        .rst_n_i (pwr_good_i),
        .set_i   (hold_active | req_valid),
        .wr_i    (cpu_wr_i),
        .addr_i  (cpu_addr_i),
        .data_i  (cpu_data_i),
        .flag_o  (overlay)
    );

    addr_overlay_map #(
        .ADDR_W (ADDR_W)
    ) u_map (
        .addr_i        (cpu_addr_i),
        .overlay_i     (overlay),
        .phys_o        (phys_addr_o),
        .ram_inhibit_o (ram_inhibit_o)
    );

    assign sys_rst_n_o  = ~hold_active;
    assign sys_halt_n_o = ~hold_active;

    // R7
    overlay_during_reset_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !sys_rst_n_o |-> ram_inhibit_o);

    // R8
    top_bit_forced_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        ram_inhibit_o |-> phys_addr_o[ADDR_W-1]);

    // R8
    low_bits_kept_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        phys_addr_o[ADDR_W-2:0] == cpu_addr_i[ADDR_W-2:0]);

    // R5
    halt_follows_rst_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        sys_halt_n_o == sys_rst_n_o);

endmodule

// File: tb/boot_reset_seq_tb.sv
`timescale 1ns/1ps
module boot_reset_seq_tb;

    localparam int CLK_PERIOD = 100;
    localparam int PRE_DIV    = 4;
    localparam int PWR_TICKS  = 6;
    localparam int PWR_HOLD   = PRE_DIV * PWR_TICKS;
    localparam int BTN_LEN    = 10;
    localparam int SW_LEN     = 124;
    localparam logic [23:0] CLR_A = 24'hE43000;
    localparam logic [15:0] CLR_D = 16'h8000;

    logic        clk = 1'b0;
    logic        pwr_good_i = 1'b0;
    logic        btn_i = 1'b0;
    logic        sw_rst_i = 1'b0;
    logic [23:0] cpu_addr_i = '0;
    logic        cpu_wr_i = 1'b0;
    logic [15:0] cpu_data_i = '0;
    logic        sys_rst_n_o, sys_halt_n_o, ram_inhibit_o;
    logic [23:0] phys_addr_o;

    int nchk = 0;
    int nerr = 0;
    int halt_mis = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_reset_seq #(
        .PRE_DIV    (PRE_DIV),
        .PWR_TICKS  (PWR_TICKS),
        .BTN_CYCLES (BTN_LEN),
        .SW_CYCLES  (SW_LEN)
    ) u_dut (
        .clk_i        (clk),
        .pwr_good_i   (pwr_good_i),
        .btn_i        (btn_i),
        .sw_rst_i     (sw_rst_i),
        .cpu_addr_i   (cpu_addr_i),
        .cpu_wr_i     (cpu_wr_i),
        .cpu_data_i   (cpu_data_i),
        .sys_rst_n_o  (sys_rst_n_o),
        .sys_halt_n_o (sys_halt_n_o),
        .phys_addr_o  (phys_addr_o),
        .ram_inhibit_o(ram_inhibit_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_cycle(input logic [23:0] a, input logic [15:0] d, input logic w);
        cpu_addr_i = a;
        cpu_data_i = d;
        cpu_wr_i   = w;
        @(posedge clk); #1;
        cpu_wr_i   = 1'b0;
        cpu_addr_i = '0;
    endtask

    // kind: 1 button, 2 software; n = edge index on which reset is released
    task automatic run_seq(input int first, input int second, input int sec_edge, output int n);
        n = 0;
        btn_i    = (first == 1);
        sw_rst_i = (first == 2);
        do begin
            @(posedge clk); #1;
            n++;
            sw_rst_i = (second == 2 && n == sec_edge - 1);
            btn_i    = (first == 1) || (second == 1 && n >= sec_edge - 1);
            if (sys_halt_n_o !== sys_rst_n_o) halt_mis++;
        end while (sys_rst_n_o == 1'b0 && n < 2000);
        sw_rst_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk); #1;
        // R1 reset state
        chk("R1", "rst_n in power-down", sys_rst_n_o, 0);
        chk("R1", "halt_n in power-down", sys_halt_n_o, 0);
        chk("R1", "inhibit in power-down", ram_inhibit_o, 1);
        chk("R8", "vector address remap", phys_addr_o, 24'h800000);

        pwr_good_i = 1'b1;
        n = 0;
        do begin
            @(posedge clk); #1; n++;
            if (sys_halt_n_o !== sys_rst_n_o) halt_mis++;
        end while (sys_rst_n_o == 1'b0 && n < 2000);
        chk("R2", "power-up release edge", n, PWR_HOLD);
        chk("R7", "overlay after power-up", ram_inhibit_o, 1);
        chk("R9", "inhibit with overlay", ram_inhibit_o, 1);

        // R8 overlay on: every single-bit address
        for (int i = 0; i < 24; i++) begin
            cpu_addr_i = 24'(1) << i; #1;
            chk("R8", "phys with overlay", phys_addr_o, (24'(1) << i) | 24'h800000);
        end
        cpu_addr_i = '0;

        // R10 near-miss writes: each address bit, each data bit, no strobe
        for (int i = 0; i < 24; i++) begin
            wr_cycle(CLR_A ^ (24'(1) << i), CLR_D, 1'b1);
            chk("R10", "wrong address write", ram_inhibit_o, 1);
        end
        for (int j = 0; j < 16; j++) begin
            wr_cycle(CLR_A, CLR_D ^ (16'(1) << j), 1'b1);
            chk("R10", "wrong data write", ram_inhibit_o, 1);
        end
        wr_cycle(CLR_A, CLR_D, 1'b0);
        chk("R10", "no strobe", ram_inhibit_o, 1);
        wr_cycle(CLR_A, CLR_D, 1'b1);
        chk("R10", "clearing write", ram_inhibit_o, 0);
        chk("R9", "inhibit after clear", ram_inhibit_o, 0);
        for (int i = 0; i < 24; i++) begin
            cpu_addr_i = 24'(1) << i; #1;
            chk("R8", "phys passthrough", phys_addr_o, 24'(1) << i);
        end
        cpu_addr_i = '0;

        // R4 software reset
        run_seq(2, 0, 0, n);
        chk("R4", "software release edge", n, SW_LEN + 1);
        chk("R7", "overlay after software reset", ram_inhibit_o, 1);
        wr_cycle(CLR_A, CLR_D, 1'b1);

        // R3 button reset, then held without retrigger
        run_seq(1, 0, 0, n);
        chk("R3", "button release edge", n, BTN_LEN + 1);
        n = 0;
        repeat (20) begin
            @(posedge clk); #1;
            if (sys_rst_n_o !== 1'b1) n++;
        end
        chk("R3", "held button cycles in reset", n, 0);
        btn_i = 1'b0;
        @(posedge clk); #1;
        chk("R7", "overlay after button reset", ram_inhibit_o, 1);
        wr_cycle(CLR_A, CLR_D, 1'b1);

        // R6 overlapping requests
        run_seq(2, 2, 51, n);
        chk("R6", "software then software", n, 51 + SW_LEN);
        run_seq(2, 1, 51, n);
        chk("R6", "software then button", n, 51 + SW_LEN);
        btn_i = 1'b0; @(posedge clk); #1;
        run_seq(1, 2, 6, n);
        chk("R6", "button then software", n, 6 + SW_LEN);
        btn_i = 1'b0; @(posedge clk); #1;
        chk("R5", "halt mismatches", halt_mis, 0);
        wr_cycle(CLR_A, CLR_D, 1'b1);

        // R10 write during reset is ignored
        sw_rst_i = 1'b1;
        @(posedge clk); #1;
        sw_rst_i = 1'b0;
        repeat (20) @(posedge clk); #1;
        wr_cycle(CLR_A, CLR_D, 1'b1);
        while (sys_rst_n_o == 1'b0) begin @(posedge clk); #1; end
        chk("R10", "write during reset", ram_inhibit_o, 1);
        wr_cycle(CLR_A, CLR_D, 1'b1);
        chk("R10", "clear after reset", ram_inhibit_o, 0);

        // R11 request and clearing write in the same cycle
        sw_rst_i = 1'b1;
        wr_cycle(CLR_A, CLR_D, 1'b1);
        sw_rst_i = 1'b0;
        chk("R11", "flag kept on collision", ram_inhibit_o, 1);
        chk("R11", "reset taken on collision", sys_rst_n_o, 0);
        while (sys_rst_n_o == 1'b0) begin @(posedge clk); #1; end
        wr_cycle(CLR_A, CLR_D, 1'b1);

        // R1 asynchronous entry, then R6 button during power-up hold
        pwr_good_i = 1'b0; #1;
        chk("R1", "async reset entry", sys_rst_n_o, 0);
        chk("R1", "async halt entry", sys_halt_n_o, 0);
        chk("R1", "async overlay entry", ram_inhibit_o, 1);
        @(posedge clk); #1;
        pwr_good_i = 1'b1;
        n = 0;
        do begin
            @(posedge clk); #1; n++;
            btn_i = (n >= 9);
        end while (sys_rst_n_o == 1'b0 && n < 2000);
        btn_i = 1'b0;
        chk("R6", "button during power hold", n, 10 + PWR_HOLD);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule